// File: doc/BRIEF.md
# Doze and Postscaler Clock Controller

This block turns one fast input clock into two clock-enable strobes, both controlled by a 16-bit control register. The first strobe, the system tick, divides the input clock by a power of two that a 3-bit select field picks. The second strobe, the doze tick, marks a subset of system ticks. A 3-bit ratio field picks how many, and a doze enable bit turns the ratio on or off. Downstream logic uses the system tick as its clock enable for the CPU and the doze tick as its clock enable for the peripherals.

An optional recovery mode drops the doze ratio back to 1:1 when an interrupt arrives. When the recovery flag is set, an interrupt pulse clears the doze enable bit in hardware. Both strobes come from counters that restart whenever their divisor changes. As a result, a new setting takes effect within one of its own periods.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 16'h3100. In that value, bit 15 (recovery flag) is 0, bits 14:12 (doze ratio code) are 3'b011, bit 11 (doze enable) is 0, and bits 10:8 (postscaler code) are 3'b001.
- R2: A write with `wr_en` high loads `wr_data[15:8]` into the fields at the same bit positions. `rd_data` shows the new value from the following cycle, and `rd_data[7:0]` always reads zero.
- R3: Postscaler code c gives a divisor N = 2^c for c = 0..6 and N = 256 for c = 7. `post_en` is a one-cycle pulse once every N clocks. At N = 1 it stays high continuously.
- R4: When the postscaler code changes, the postscaler counter restarts. The first `post_en` pulse after a write comes on the (N+1)th rising edge after the write edge.
- R5: With doze enabled, ratio code r gives M = 2^r. `doze_en` pulses together with every Mth `post_en` pulse and never without one. With doze disabled, `doze_en` equals `post_en`.
- R6: When the recovery flag is 1, an `irq` pulse clears the doze enable bit on that edge. This clear takes priority over a register write in the same cycle.
- R7: When the recovery flag is 0, `irq` has no effect on the doze enable bit.
- R8: When the effective doze ratio changes, the doze counter restarts. The first `doze_en` pulse then coincides with the Mth `post_en` pulse that follows the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| irq | input | 1 | Interrupt pulse |
| rd_data | output | 16 | Register read value |
| post_en | output | 1 | System (postscaled) clock enable |
| doze_en | output | 1 | Peripheral (doze) clock enable |

## Verification
The assertions check the following on every cycle:
- Each divider counter stays below its current divisor.
- A strobe never stays high for two cycles when its divisor is above one.
- A divide-by-one strobe copies its advance input.
- The doze strobe only fires together with a system tick.
- The interrupt clear and interrupt immunity hold in the register.

Only the bench's reference model can show the following:
- The exact spacing of pulses for each of the sixteen codes.
- The restart position after a change of code.
- The jump from divide-by-64 to divide-by-256.
- The outcome of a write colliding with an interrupt.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_W = 9;

  typedef struct packed {
    logic       roi;
    logic [2:0] ratio;
    logic       doze_on;
    logic [2:0] psel;
  } ctl_t;

  function automatic logic [DIV_W-1:0] post_div(input logic [2:0] c);
    return (c == 3'd7) ? DIV_W'(256) : (DIV_W'(1) << c);
  endfunction

  function automatic logic [DIV_W-1:0] doze_div(input logic [2:0] c);
    return DIV_W'(1) << c;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter ctl_t RST_VAL = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  ctl_t wr_ctl,
  input  logic irq,
  output ctl_t ctl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= RST_VAL;
    end else begin
      if (wr_en) ctl <= wr_ctl;
      if (irq && ctl.roi) ctl.doze_on <= 1'b0;
    end
  end

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && ctl.roi) |=> !ctl.doze_on);

  // R7
  irq_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !ctl.roi && !wr_en) |=> $stable(ctl.doze_on));
endmodule

// File: rtl/clkdiv_strobe.sv
module clkdiv_strobe
  import clkdiv_pkg::*;
#(
  parameter bit         IS_POST  = 1'b1,
  parameter int         CNT_W    = 8,
  parameter logic [2:0] RST_CODE = 3'd0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic [2:0] code,
  output logic       fire,
  output logic       tick
);
  logic [2:0]       prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] cur_div;
  logic             chg;
  logic             at_end;

  generate
    if (IS_POST) begin : g_post
      assign cur_div = post_div(code);
    end else begin : g_doze
      assign cur_div = doze_div(code);
    end
  endgenerate

  assign chg    = (code != prev_q);
  assign at_end = (DIV_W'(cnt_q) == cur_div - DIV_W'(1));
  assign fire   = !chg && adv && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= RST_CODE;
      cnt_q  <= '0;
      tick   <= 1'b0;
    end else begin
      prev_q <= code;
      tick   <= fire;
      if (chg)      cnt_q <= '0;
      else if (adv) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  // R4 R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !chg |-> (DIV_W'(cnt_q) < cur_div));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cur_div > DIV_W'(1)) |=> !tick);

  // R3
  div_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!chg && cur_div == DIV_W'(1)) |=> (tick == $past(adv)));
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq,
  output logic [DATA_W-1:0] rd_data,
  output logic              post_en,
  output logic              doze_en
);
  localparam int   FLD_W   = $bits(ctl_t);
  localparam int   FLD_LSB = DATA_W - FLD_W;
  localparam ctl_t RST_CTL = '{roi: 1'b0, ratio: 3'd3, doze_on: 1'b0, psel: 3'd1};

  ctl_t       ctl;
  ctl_t       wr_ctl;
  logic [2:0] doze_code;
  logic       post_fire;
  logic       doze_fire;

  assign wr_ctl    = ctl_t'(wr_data[DATA_W-1:FLD_LSB]);
  assign doze_code = ctl.doze_on ? ctl.ratio : 3'd0;
  assign rd_data   = {ctl, {FLD_LSB{1'b0}}};

  clkdiv_regs #(.RST_VAL(RST_CTL)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_ctl (wr_ctl),
    .irq    (irq),
    .ctl    (ctl)
  );

  clkdiv_strobe #(.IS_POST(1'b1), .CNT_W(CNT_W), .RST_CODE(RST_CTL.psel)) u_post (
    .clk  (clk),
    .rst  (rst),
    .adv  (1'b1),
    .code (ctl.psel),
    .fire (post_fire),
    .tick (post_en)
  );

  clkdiv_strobe #(.IS_POST(1'b0), .CNT_W(CNT_W), .RST_CODE(3'd0)) u_doze (
    .clk  (clk),
    .rst  (rst),
    .adv  (post_fire),
    .code (doze_code),
    .fire (doze_fire),
    .tick (doze_en)
  );

  // R5
  doze_in_post_chk: assert property (@(posedge clk) disable iff (rst)
    doze_en |-> post_en);

  // R5
  doze_fire_chk: assert property (@(posedge clk) disable iff (rst)
    doze_fire |-> post_fire);
endmodule

// File: tb/sim_clkdiv_ctrl.sv
module sim_clkdiv_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq = 1'b0;
  logic [15:0] rd_data;
  logic        post_en;
  logic        doze_en;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit running = 0;
  string tag_p = "R3";
  string tag_d = "R5";

  // reference model state
  int m_roi = 0, m_ratio = 3, m_don = 0, m_psel = 1;
  int pcnt = 0, pprev = 1, ptick = 0;
  int dcnt = 0, dprev = 0, dtick = 0;

  always #2 clk = ~clk;

  clkdiv_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .irq(irq),
    .rd_data(rd_data), .post_en(post_en), .doze_en(doze_en)
  );

  function automatic int pdiv(int c);
    return (c == 7) ? 256 : (1 << c);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_roi = 0; m_ratio = 3; m_don = 0; m_psel = 1;
      pcnt = 0; pprev = 1; ptick = 0;
      dcnt = 0; dprev = 0; dtick = 0;
    end else begin
      int pd, deff, dd, pfire, dfire;
      pd = pdiv(m_psel);
      pfire = (m_psel == pprev) && (pcnt == pd - 1);
      if (m_psel != pprev) pcnt = 0;
      else pcnt = (pcnt == pd - 1) ? 0 : pcnt + 1;
      ptick = pfire;
      pprev = m_psel;
      deff = m_don ? m_ratio : 0;
      dd = 1 << deff;
      dfire = (deff == dprev) && pfire && (dcnt == dd - 1);
      if (deff != dprev) dcnt = 0;
      else if (pfire) dcnt = (dcnt == dd - 1) ? 0 : dcnt + 1;
      dtick = dfire;
      dprev = deff;
      if (wr_en) begin
        int old_roi;
        old_roi = m_roi;
        m_roi = wr_data[15]; m_ratio = wr_data[14:12];
        m_don = wr_data[11]; m_psel = wr_data[10:8];
        if (irq && old_roi) m_don = 0;
      end else if (irq && m_roi) begin
        m_don = 0;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (running) begin
      check(rd_data == {m_roi[0], m_ratio[2:0], m_don[0], m_psel[2:0], 8'h00},
            "R2", rd_data,
            {m_roi[0], m_ratio[2:0], m_don[0], m_psel[2:0], 8'h00});
      check(post_en == ptick[0], tag_p, post_en, ptick);
      check(doze_en == dtick[0], tag_d, doze_en, dtick);
    end
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] v, bit with_irq);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; irq = with_irq;
    @(negedge clk);
    wr_en = 1'b0; irq = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset value
    check(rd_data == 16'h3100, "R1", rd_data, 16'h3100);
    check(post_en == 1'b0 && doze_en == 1'b0, "R1", {post_en, doze_en}, 0);
    running = 1;
    idle(20);

    // R3 R4: every postscaler code, doze off; low byte written nonzero (R2)
    for (int c = 0; c < 8; c++) begin
      tag_p = "R4";
      wr({1'b0, 3'd3, 1'b0, c[2:0], 8'hFF}, 1'b0);
      idle(pdiv(c) + 2);
      tag_p = "R3";
      idle(pdiv(c) * 2 + 6);
    end

    // R5 R8: doze ratios at full speed, then under divide-by-2
    for (int r = 0; r < 8; r++) begin
      tag_d = "R8";
      wr({1'b0, r[2:0], 1'b1, 3'd0, 8'h00}, 1'b0);
      idle((1 << r) + 2);
      tag_d = "R5";
      idle((1 << r) * 2 + 6);
    end
    tag_d = "R8";
    wr({1'b0, 3'd2, 1'b1, 3'd1, 8'h00}, 1'b0);
    idle(12);
    tag_d = "R5";
    idle(40);

    // R6: recovery clears doze enable
    tag_d = "R6";
    wr({1'b1, 3'd3, 1'b1, 3'd0, 8'h00}, 1'b0);
    idle(20);
    pulse_irq();
    check(rd_data[11] == 1'b0, "R6", rd_data[11], 0);
    idle(20);

    // R6: write of doze enable collides with interrupt; clear wins
    wr({1'b1, 3'd2, 1'b1, 3'd0, 8'h00}, 1'b1);
    check(rd_data[11] == 1'b0, "R6", rd_data[11], 0);
    idle(20);

    // R7: recovery off, interrupt has no effect
    tag_d = "R7";
    wr({1'b0, 3'd2, 1'b1, 3'd0, 8'h00}, 1'b0);
    idle(10);
    pulse_irq();
    check(rd_data[11] == 1'b1, "R7", rd_data[11], 1);
    idle(20);

    // reset mid-run returns to defaults (R1)
    @(negedge clk);
    running = 0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 16'h3100, "R1", rd_data, 16'h3100);
    running = 1;
    tag_p = "R3"; tag_d = "R5";
    idle(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule